// File: doc/BRIEF.md
# SPI Master Channel Transfer Event Controller

This block governs one full-duplex SPI master channel. Each cycle it decides whether the next word may go to the serial shifter, and it keeps three sticky event flags: transmit underflow, receive full and end of word count. The shifter and the FIFO storage sit outside the block. It sees them only through occupancy flags, a byte level, a ready request and a done pulse.

Two events are shaped to avoid false alarms. The underflow warning stays quiet until software has written at least one word since the channel was enabled. In FIFO mode, receive full fires once and then waits until the host has made as many reads as the almost-full level. A nonzero word count stops the channel when it expires. The channel stays halted until software rewrites the count and enables the channel again.

Status bits are cleared by writing 1. A registered interrupt line reports any status bit whose enable is set. Bit positions: 0 is underflow, 1 is receive full, 2 is end of word count.

Top module: `spi_xfer_evt_ctrl`

## Requirements
- R1: While `chan_en` is low, `shift_start` stays low one cycle later, and no status bit goes from 0 to 1.
- R2: `shift_start` is high in the cycle after a cycle in which `chan_en`, `shift_ready` and not `rx_full_flag` hold and the channel is not halted; otherwise it is low.
- R3: While `rx_full_flag` is high, no word is granted, so received data is never overwritten. A grant that does not happen raises no underflow.
- R4: Status bit 0 (underflow) sets when a grant occurs while `tx_empty` is high and `tx_load` was seen in an earlier cycle since the channel was last enabled.
- R5: With no `tx_load` since the last enable, a grant with `tx_empty` high leaves status bit 0 clear. Dropping `chan_en` forgets earlier loads.
- R6: With `rx_fifo_en` low, status bit 1 sets in the cycle after `rx_word_valid` is high while enabled.
- R7: With `rx_fifo_en` high, status bit 1 sets when `rx_level` is at least a nonzero `afl_level`, and not while it is below.
- R8: After a FIFO receive-full event, no new one is raised until `afl_level` host reads (`host_rd` pulses) have been counted. The event can fire in the cycle after the last of those reads.
- R9: With either FIFO enabled and `wcnt` nonzero, the `wcnt`-th `shift_done` pulse after the last `wcnt_wr` sets status bit 2 and `halted` in the next cycle.
- R10: With `wcnt` zero, or with both FIFO enables low, status bit 2 never sets.
- R11: While `halted` is high, no word is granted. The halt clears only on a rising edge of `chan_en` that comes after a `wcnt_wr` seen while halted.
- R12: Status bits are sticky. A 1 in `stat_clr` clears that bit, and a new event in the same cycle wins over the clear.
- R13: `irq` equals the OR of `status & irq_en`, registered so it lines up with `status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable |
| tx_fifo_en | input | 1 | Transmit FIFO in use |
| rx_fifo_en | input | 1 | Receive FIFO in use |
| tx_empty | input | 1 | Transmit register or FIFO empty |
| tx_load | input | 1 | Host wrote transmit data this cycle |
| rx_full_flag | input | 1 | Receive register or FIFO has no room |
| rx_word_valid | input | 1 | Receive register holds a word (non-FIFO mode) |
| rx_level | input | LVL_W | Bytes held in the receive FIFO |
| afl_level | input | LVL_W | Almost-full threshold in bytes |
| host_rd | input | 1 | Host read strobe on the receive side |
| wcnt | input | WCNT_W | Word count, 0 disables |
| wcnt_wr | input | 1 | Word count rewritten this cycle |
| shift_ready | input | 1 | Shifter requests the next word |
| shift_done | input | 1 | Shifter finished one word |
| irq_en | input | 3 | Per-event interrupt enables |
| stat_clr | input | 3 | Write-1-to-clear strobes for status |
| shift_start | output | 1 | Registered grant of a word to the shifter |
| halted | output | 1 | Transfers stopped after word count expiry |
| status | output | 3 | Sticky events: 0 underflow, 1 rx full, 2 end of count |
| irq | output | 1 | Registered combined interrupt |

## Verification
The bound checker watches, on every cycle, the properties that hold instant by instant:
- grant gating by enable, receive-full and halt;
- status stickiness, with no new bit while disabled;
- interrupt alignment with status;
- end-of-count only with a nonzero count and a FIFO enabled, together with the halt.

Behaviours that depend on history can only be shown by the bench's scenarios against its reference model:
- underflow suppression before the first load;
- re-arming of receive full after the right number of reads;
- the exact word on which the count expires;
- the two-step release from halt.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;
  localparam int EVT_N  = 3;
  localparam int EV_UFL = 0;
  localparam int EV_RXF = 1;
  localparam int EV_EOW = 2;
  typedef logic [EVT_N-1:0] evt_vec_t;
endpackage

// File: rtl/spi_tx_sched.sv
module spi_tx_sched (
  input  logic clk,
  input  logic rst,
  input  logic chan_en,
  input  logic shift_ready,
  input  logic rx_full_flag,
  input  logic halted,
  input  logic tx_empty,
  input  logic tx_load,
  output logic ufl_evt,
  output logic shift_start
);
  logic grant;
  logic loaded_q;

  // a word may go out only if there is room to receive the reply
  assign grant   = chan_en & shift_ready & ~rx_full_flag & ~halted;
  assign ufl_evt = grant & tx_empty & loaded_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      loaded_q    <= 1'b0;
      shift_start <= 1'b0;
    end else begin
      shift_start <= grant;
      if (!chan_en)     loaded_q <= 1'b0;
      else if (tx_load) loaded_q <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_rx_evt.sv
module spi_rx_evt #(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chan_en,
  input  logic             rx_fifo_en,
  input  logic             rx_word_valid,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] afl_level,
  input  logic             host_rd,
  output logic             rxf_evt
);
  logic             armed_q;
  logic [LVL_W-1:0] rd_cnt_q;
  logic [LVL_W:0]   rd_nxt;
  logic             fifo_hit;

  assign rd_nxt   = {1'b0, rd_cnt_q} + {{LVL_W{1'b0}}, 1'b1};
  assign fifo_hit = armed_q & (afl_level != '0) & (rx_level >= afl_level);
  assign rxf_evt  = chan_en & (rx_fifo_en ? fifo_hit : rx_word_valid);

  always_ff @(posedge clk) begin
    if (rst || !chan_en) begin
      armed_q  <= 1'b1;
      rd_cnt_q <= '0;
    end else if (rx_fifo_en) begin
      if (rxf_evt) begin
        armed_q  <= 1'b0;
        rd_cnt_q <= '0;
      end else if (!armed_q && host_rd) begin
        if (rd_nxt >= {1'b0, afl_level}) begin
          armed_q  <= 1'b1;
          rd_cnt_q <= '0;
        end else begin
          rd_cnt_q <= rd_nxt[LVL_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/spi_wcnt_ctrl.sv
module spi_wcnt_ctrl #(
  parameter int WCNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chan_en,
  input  logic              fifo_used,
  input  logic [WCNT_W-1:0] wcnt,
  input  logic              wcnt_wr,
  input  logic              shift_done,
  output logic              eow_evt,
  output logic              halted
);
  logic [WCNT_W-1:0] cnt_q;
  logic [WCNT_W:0]   cnt_nxt;
  logic              rewr_q;
  logic              en_d_q;
  logic              counting;
  logic              release_now;

  assign cnt_nxt     = {1'b0, cnt_q} + {{WCNT_W{1'b0}}, 1'b1};
  assign counting    = chan_en & fifo_used & (wcnt != '0) & ~halted & shift_done;
  assign eow_evt     = counting & ~wcnt_wr & (cnt_nxt >= {1'b0, wcnt});
  assign release_now = halted & rewr_q & chan_en & ~en_d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      rewr_q <= 1'b0;
      en_d_q <= 1'b0;
      halted <= 1'b0;
    end else begin
      en_d_q <= chan_en;
      if (wcnt_wr)       cnt_q <= '0;
      else if (eow_evt)  cnt_q <= '0;
      else if (counting) cnt_q <= cnt_nxt[WCNT_W-1:0];

      if (eow_evt) begin
        halted <= 1'b1;
      end else if (release_now) begin
        halted <= 1'b0;
        rewr_q <= 1'b0;
      end else if (halted && wcnt_wr) begin
        rewr_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_evt_status.sv
module spi_evt_status
  import spi_evt_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  evt_vec_t evt,
  input  evt_vec_t clr,
  input  evt_vec_t en,
  output evt_vec_t status,
  output logic     irq
);
  evt_vec_t st_next;

  for (genvar i = 0; i < EVT_N; i++) begin : g_bit
    assign st_next[i] = evt[i] | (status[i] & ~clr[i]);
    always_ff @(posedge clk) begin
      if (rst) status[i] <= 1'b0;
      else     status[i] <= st_next[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(st_next & en);
  end
endmodule

// File: rtl/spi_xfer_evt_ctrl.sv
module spi_xfer_evt_ctrl
  import spi_evt_pkg::*;
#(
  parameter int FIFO_BYTES = 64,
  parameter int WCNT_W     = 16,
  localparam int LVL_W     = $clog2(FIFO_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chan_en,
  input  logic              tx_fifo_en,
  input  logic              rx_fifo_en,
  input  logic              tx_empty,
  input  logic              tx_load,
  input  logic              rx_full_flag,
  input  logic              rx_word_valid,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [LVL_W-1:0]  afl_level,
  input  logic              host_rd,
  input  logic [WCNT_W-1:0] wcnt,
  input  logic              wcnt_wr,
  input  logic              shift_ready,
  input  logic              shift_done,
  input  logic [2:0]        irq_en,
  input  logic [2:0]        stat_clr,
  output logic              shift_start,
  output logic              halted,
  output logic [2:0]        status,
  output logic              irq
);
  evt_vec_t evt;
  logic     ufl_evt, rxf_evt, eow_evt;

  spi_tx_sched u_tx (
    .clk, .rst, .chan_en, .shift_ready, .rx_full_flag,
    .halted, .tx_empty, .tx_load, .ufl_evt, .shift_start
  );

  spi_rx_evt #(.LVL_W(LVL_W)) u_rx (
    .clk, .rst, .chan_en, .rx_fifo_en, .rx_word_valid,
    .rx_level, .afl_level, .host_rd, .rxf_evt
  );

  spi_wcnt_ctrl #(.WCNT_W(WCNT_W)) u_wc (
    .clk, .rst, .chan_en, .fifo_used(tx_fifo_en | rx_fifo_en),
    .wcnt, .wcnt_wr, .shift_done, .eow_evt, .halted
  );

  always_comb begin
    evt         = '0;
    evt[EV_UFL] = ufl_evt;
    evt[EV_RXF] = rxf_evt;
    evt[EV_EOW] = eow_evt;
  end

  spi_evt_status u_st (
    .clk, .rst, .evt, .clr(stat_clr), .en(irq_en), .status, .irq
  );
endmodule

// File: rtl/spi_xfer_evt_ctrl_chk.sv
module spi_xfer_evt_ctrl_chk #(
  parameter int WCNT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              chan_en,
  input logic              shift_ready,
  input logic              rx_full_flag,
  input logic              tx_fifo_en,
  input logic              rx_fifo_en,
  input logic [WCNT_W-1:0] wcnt,
  input logic [2:0]        stat_clr,
  input logic [2:0]        irq_en,
  input logic              shift_start,
  input logic              halted,
  input logic [2:0]        status,
  input logic              irq
);
  assert_no_start_disabled_R1: assert property (@(posedge clk) disable iff (rst)
    !chan_en |=> !shift_start);

  assert_no_new_event_disabled_R1: assert property (@(posedge clk) disable iff (rst)
    !chan_en |=> ((status & ~$past(status)) == 3'b000));

  assert_grant_when_eligible_R2: assert property (@(posedge clk) disable iff (rst)
    (chan_en && shift_ready && !rx_full_flag && !halted) |=> shift_start);

  assert_no_overwrite_R3: assert property (@(posedge clk) disable iff (rst)
    rx_full_flag |=> !shift_start);

  assert_eow_halts_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(status[2]) |-> halted);

  assert_eow_needs_count_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(status[2]) |-> $past((wcnt != '0) && (tx_fifo_en || rx_fifo_en)));

  assert_halt_blocks_R11: assert property (@(posedge clk) disable iff (rst)
    halted |=> !shift_start);

  assert_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(status) & ~$past(stat_clr)) & ~status) == 3'b000));

  assert_irq_matches_R13: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |(status & $past(irq_en))));
endmodule

bind spi_xfer_evt_ctrl spi_xfer_evt_ctrl_chk #(.WCNT_W(WCNT_W)) chk_i (.*);

// File: tb/spi_xfer_evt_ctrl_tb_top.sv
module spi_xfer_evt_ctrl_tb_top;
  localparam int LW = 7;
  localparam int WW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chan_en = 0, tx_fifo_en = 0, rx_fifo_en = 0, tx_empty = 0, tx_load = 0;
  logic rx_full_flag = 0, rx_word_valid = 0, host_rd = 0, wcnt_wr = 0;
  logic shift_ready = 0, shift_done = 0;
  logic [LW-1:0] rx_level = '0, afl_level = '0;
  logic [WW-1:0] wcnt = '0;
  logic [2:0] irq_en = 3'b111, stat_clr = 3'b000;
  logic shift_start, halted, irq;
  logic [2:0] status;

  int vecs = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_xfer_evt_ctrl dut_i (.*);

  // reference model, behavioural
  bit m_start, m_halt, m_irq, m_loaded, m_armed, m_rewr, m_en_d;
  bit [2:0] m_st;
  int m_rd, m_cnt;
  bit go, e_u, e_r, e_w, fifo_on;

  always @(posedge clk) begin
    if (rst) begin
      m_start = 0; m_halt = 0; m_irq = 0; m_loaded = 0; m_armed = 1;
      m_rewr = 0; m_en_d = 0; m_st = 0; m_rd = 0; m_cnt = 0;
    end else begin
      go  = chan_en && shift_ready && !rx_full_flag && !m_halt;
      e_u = go && tx_empty && m_loaded;
      if (rx_fifo_en) e_r = chan_en && m_armed && afl_level != 0 && rx_level >= afl_level;
      else            e_r = chan_en && rx_word_valid;
      fifo_on = tx_fifo_en || rx_fifo_en;
      e_w = 0;
      if (wcnt_wr) m_cnt = 0;
      else if (chan_en && fifo_on && wcnt != 0 && !m_halt && shift_done) begin
        m_cnt++;
        if (m_cnt >= int'(wcnt)) begin e_w = 1; m_cnt = 0; end
      end
      if (e_w) m_halt = 1;
      else if (m_halt && m_rewr && chan_en && !m_en_d) begin m_halt = 0; m_rewr = 0; end
      else if (m_halt && wcnt_wr) m_rewr = 1;
      if (!chan_en) begin m_armed = 1; m_rd = 0; end
      else if (rx_fifo_en) begin
        if (e_r) begin m_armed = 0; m_rd = 0; end
        else if (!m_armed && host_rd) begin
          m_rd++;
          if (m_rd >= int'(afl_level)) begin m_armed = 1; m_rd = 0; end
        end
      end
      if (!chan_en) m_loaded = 0; else if (tx_load) m_loaded = 1;
      m_en_d  = chan_en;
      m_start = go;
      m_st    = (m_st & ~stat_clr) | {e_w, e_r, e_u};
      m_irq   = |(m_st & irq_en);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 model shift_start", shift_start, m_start);
      chk("R4 model underflow", status[0], m_st[0]);
      chk("R6 model rx_full", status[1], m_st[1]);
      chk("R9 model eow", status[2], m_st[2]);
      chk("R11 model halted", halted, m_halt);
      chk("R13 model irq", irq, m_irq);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_done(input int n);
    for (int i = 0; i < n; i++) begin
      shift_done = 1; cyc(1); shift_done = 0; cyc(1);
    end
  endtask

  initial begin
    cyc(4); rst = 0; cyc(1);
    chk("R1 reset status", status, 0);
    chk("R1 reset start", shift_start, 0);
    chk("R1 reset irq", irq, 0);

    // disabled channel: nothing happens
    shift_ready = 1; rx_word_valid = 1; tx_empty = 1; cyc(3);
    chk("R1 disabled start", shift_start, 0);
    chk("R1 disabled status", status, 0);
    shift_ready = 0; rx_word_valid = 0;

    // first grant, no load yet
    chan_en = 1; cyc(1);
    shift_ready = 1; cyc(1); shift_ready = 0;
    chk("R2 grant", shift_start, 1);
    chk("R5 no underflow before load", status[0], 0);

    // load, then empty at grant
    tx_load = 1; cyc(1); tx_load = 0;
    shift_ready = 1; cyc(1); shift_ready = 0;
    chk("R4 underflow set", status[0], 1);
    chk("R13 irq on", irq, 1);

    // clear, then clear against new event
    stat_clr = 3'b001; cyc(1); stat_clr = 0;
    chk("R12 w1c", status[0], 0);
    stat_clr = 3'b001; shift_ready = 1; cyc(1); stat_clr = 0; shift_ready = 0;
    chk("R12 event beats clear", status[0], 1);
    cyc(2);
    chk("R12 sticky", status[0], 1);
    stat_clr = 3'b111; cyc(1); stat_clr = 0;

    // disable forgets load
    chan_en = 0; cyc(1); chan_en = 1; cyc(1);
    shift_ready = 1; cyc(1); shift_ready = 0;
    chk("R5 load forgotten", status[0], 0);

    // receive side full blocks grant
    tx_load = 1; cyc(1); tx_load = 0;
    rx_full_flag = 1; shift_ready = 1; cyc(2);
    chk("R3 no grant", shift_start, 0);
    chk("R3 no underflow", status[0], 0);
    rx_full_flag = 0; shift_ready = 0; tx_empty = 0; cyc(1);

    // non-FIFO receive full
    rx_word_valid = 1; cyc(1); rx_word_valid = 0;
    chk("R6 rx full", status[1], 1);
    stat_clr = 3'b010; cyc(1); stat_clr = 0;

    // FIFO receive full with re-arm
    rx_fifo_en = 1; afl_level = 4; rx_level = 3; cyc(2);
    chk("R7 below level", status[1], 0);
    rx_level = 4; cyc(1);
    chk("R7 at level", status[1], 1);
    stat_clr = 3'b010; cyc(1); stat_clr = 0;
    chk("R8 cleared", status[1], 0);
    for (int i = 0; i < 3; i++) begin host_rd = 1; cyc(1); host_rd = 0; cyc(1); end
    chk("R8 not rearmed", status[1], 0);
    host_rd = 1; cyc(1); host_rd = 0; cyc(1);
    chk("R8 rearmed", status[1], 1);
    rx_fifo_en = 0; rx_level = 0; stat_clr = 3'b111; cyc(1); stat_clr = 0;

    // word count expiry
    tx_fifo_en = 1; wcnt = 3; wcnt_wr = 1; cyc(1); wcnt_wr = 0;
    pulse_done(2);
    chk("R9 not yet", status[2], 0);
    shift_done = 1; cyc(1); shift_done = 0;
    chk("R9 eow", status[2], 1);
    chk("R9 halted", halted, 1);
    shift_ready = 1; cyc(2);
    chk("R11 halt blocks", shift_start, 0);
    shift_ready = 0;
    chan_en = 0; cyc(1); chan_en = 1; cyc(2);
    chk("R11 needs rewrite", halted, 1);
    wcnt_wr = 1; cyc(1); wcnt_wr = 0;
    chk("R11 needs reenable", halted, 1);
    chan_en = 0; cyc(1); chan_en = 1; cyc(1);
    chk("R11 released", halted, 0);
    stat_clr = 3'b111; cyc(1); stat_clr = 0;

    // zero count and no FIFO
    wcnt = 0; wcnt_wr = 1; cyc(1); wcnt_wr = 0;
    pulse_done(5);
    chk("R10 zero count", status[2], 0);
    tx_fifo_en = 0; wcnt = 2; wcnt_wr = 1; cyc(1); wcnt_wr = 0;
    pulse_done(3);
    chk("R10 no fifo", status[2], 0);

    // interrupt masking
    rx_word_valid = 1; cyc(1); rx_word_valid = 0;
    irq_en = 3'b000; cyc(1);
    chk("R13 masked", irq, 0);
    irq_en = 3'b010; cyc(1);
    chk("R13 unmasked", irq, 1);
    cyc(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule